// File: doc/BRIEF.md
# Write-Then-Poll Host Sequencer for Two-Wire Serial Memory

This block sits on the host side of a two-wire serial memory bus. It sits above a byte-level bus master engine and hands it commands one at a time. A requester presents a chip select, a memory address and a byte count. The sequencer then emits the whole page write: a Start, a control byte, two address bytes, the data bytes and a Stop. That Stop starts the memory's internal programming cycle.

The sequencer does not wait a fixed programming time. Right after the Stop it re-addresses the device with a Start and a write-type control byte. A missing acknowledge means the device is still busy, so the sequencer sends Start and the control byte again. The first acknowledged poll completes the request. A programmable poll limit bounds the wait. Requests that would run past the end of a page are refused before any bus activity. NACKs from the engine and bus faults reported by the engine end the request with a distinct status.

The requester supplies data bytes through an index/byte lookup. The sequencer shows the index of the byte it wants, and the requester returns that byte combinationally.

Top module: `ack_poll_sequencer`

## Requirements
- R1: A request whose length is 0, or whose page offset (address bits [4:0]) plus length exceeds 32, is refused. `done_status` is 4 (reject), `done_valid` is raised in the cycle after acceptance, and no engine command is issued.
- R2: A valid request produces this command order, using op codes 0 = Start, 1 = write byte, 2 = Stop:
  - Start
  - the control byte `{4'b1010, cs, 1'b0}`
  - the address high byte (upper four bits zero, then address bits [11:8])
  - the address low byte
  - data bytes for indices 0 to len-1, in order
  - Stop
- R3: Right after the write Stop, the sequencer repeats the poll pair (Start, then the same control byte) for as long as the poll byte is answered with NACK.
- R4: When a poll is acknowledged, status is 0 (ok). A closing Stop is issued unless `req_hold_bus` was set, in which case the request completes with the bus left open.
- R5: The request times out after N NACKed polls, where N = max(`req_max_polls`, 1). On timeout a Stop is issued and status is 1.
- R6: A NACK on any byte of the write command (control, address or data) is followed by a Stop and status 2, and no polling takes place.
- R7: An engine error response ends the request immediately. No further command is issued and status is 3.
- R8: Only one command is outstanding at a time. While `cmd_valid` is high and `cmd_ready` is low, the op and byte hold steady. No command is issued while the block is idle.
- R9: After reset `req_ready` is 1 and `cmd_valid` and `done_valid` are 0. `done_valid` is a one-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle, request taken this cycle |
| req_cs | input | 3 | Chip-select bits for the control byte |
| req_addr | input | 12 | Memory start address |
| req_len | input | 6 | Number of data bytes (1 to 32) |
| req_hold_bus | input | 1 | Leave bus open after the acknowledged poll |
| req_max_polls | input | 8 | Maximum number of NACKed polls |
| dat_idx | output | 5 | Index of the data byte wanted |
| dat_byte | input | 8 | Data byte at `dat_idx` |
| cmd_valid | output | 1 | Command to engine valid |
| cmd_ready | input | 1 | Engine takes the command |
| cmd_op | output | 2 | 0 Start, 1 write byte, 2 Stop |
| cmd_byte | output | 8 | Byte for a write command |
| rsp_valid | input | 1 | Engine response for the last command |
| rsp_nack | input | 1 | Written byte was not acknowledged |
| rsp_err | input | 1 | Engine bus error |
| done_valid | output | 1 | Request finished (one-cycle pulse) |
| done_status | output | 3 | 0 ok, 1 timeout, 2 NACK, 3 bus error, 4 reject |

## Verification
The hold-stability property assumes three things about the inputs:
- the requester keeps `dat_byte` a pure function of `dat_idx` for the whole request;
- the engine raises `rsp_valid` only after it has taken a command;
- the engine never answers twice.

The bench's engine model keeps to this. It accepts each command after a delay of 0 to 2 cycles, answers exactly once one cycle later, and computes the data byte from the index and a per-request seed. The poll-bound property assumes `req_max_polls` is sampled once at acceptance. The bench changes it only between requests.

// File: rtl/ack_poll_sequencer.sv
module ack_poll_sequencer #(
  parameter int ADDR_W     = 12,
  parameter int PAGE_BYTES = 32,
  parameter int POLL_W     = 8
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             req_valid,
  output logic                             req_ready,
  input  logic [2:0]                       req_cs,
  input  logic [ADDR_W-1:0]                req_addr,
  input  logic [$clog2(PAGE_BYTES):0]      req_len,
  input  logic                             req_hold_bus,
  input  logic [POLL_W-1:0]                req_max_polls,
  output logic [$clog2(PAGE_BYTES)-1:0]    dat_idx,
  input  logic [7:0]                       dat_byte,
  output logic                             cmd_valid,
  input  logic                             cmd_ready,
  output logic [1:0]                       cmd_op,
  output logic [7:0]                       cmd_byte,
  input  logic                             rsp_valid,
  input  logic                             rsp_nack,
  input  logic                             rsp_err,
  output logic                             done_valid,
  output logic [2:0]                       done_status
);
  localparam int IDX_W = $clog2(PAGE_BYTES);
  localparam int LEN_W = IDX_W + 1;
  localparam logic [LEN_W:0] PAGE_V = (LEN_W+1)'(PAGE_BYTES);
  localparam logic [1:0] OP_START = 2'd0, OP_WRITE = 2'd1, OP_STOP = 2'd2;
  localparam logic [2:0] ST_OK = 3'd0, ST_TIMEOUT = 3'd1, ST_NACK = 3'd2,
                         ST_BUSERR = 3'd3, ST_REJECT = 3'd4;

  typedef enum logic [1:0] {S_IDLE, S_CMD, S_RSP, S_FIN} state_t;
  typedef enum logic [3:0] {P_START, P_CTRL, P_AH, P_AL, P_DATA,
                            P_STOP, P_PSTART, P_PCTRL, P_END} phase_t;

  state_t              state_q;
  phase_t              phase_q;
  logic [2:0]          cs_q;
  logic [ADDR_W-1:0]   addr_q;
  logic [LEN_W-1:0]    len_q;
  logic                hold_q;
  logic [POLL_W-1:0]   maxp_q;
  logic [POLL_W-1:0]   polls_q;
  logic [IDX_W-1:0]    idx_q;
  logic [2:0]          status_q;

  wire [LEN_W:0]  span     = {{(LEN_W+1-IDX_W){1'b0}}, req_addr[IDX_W-1:0]} + {1'b0, req_len};
  wire            req_bad  = (req_len == '0) || (span > PAGE_V);
  wire            last_dat = ({1'b0, idx_q} + 1'b1) == len_q;
  wire [POLL_W:0] polls_nx = {1'b0, polls_q} + 1'b1;
  wire            poll_out = polls_nx >= {1'b0, maxp_q};
  wire [7:0]      ctrl_b   = {4'b1010, cs_q, 1'b0};
  wire [7:0]      addr_hi  = {{(16-ADDR_W){1'b0}}, addr_q[ADDR_W-1:8]};

  assign req_ready   = (state_q == S_IDLE);
  assign cmd_valid   = (state_q == S_CMD);
  assign done_valid  = (state_q == S_FIN);
  assign done_status = status_q;
  assign dat_idx     = idx_q;

  always_comb begin
    cmd_op   = OP_WRITE;
    cmd_byte = 8'h00;
    case (phase_q)
      P_START, P_PSTART: cmd_op = OP_START;
      P_STOP, P_END:     cmd_op = OP_STOP;
      P_CTRL, P_PCTRL:   cmd_byte = ctrl_b;
      P_AH:              cmd_byte = addr_hi;
      P_AL:              cmd_byte = addr_q[7:0];
      P_DATA:            cmd_byte = dat_byte;
      default:           cmd_byte = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= S_IDLE;
      phase_q  <= P_START;
      cs_q     <= '0;
      addr_q   <= '0;
      len_q    <= '0;
      hold_q   <= 1'b0;
      maxp_q   <= '0;
      polls_q  <= '0;
      idx_q    <= '0;
      status_q <= ST_OK;
    end else begin
      case (state_q)
        S_IDLE: if (req_valid) begin
          cs_q     <= req_cs;
          addr_q   <= req_addr;
          len_q    <= req_len;
          hold_q   <= req_hold_bus;
          maxp_q   <= req_max_polls;
          polls_q  <= '0;
          idx_q    <= '0;
          phase_q  <= P_START;
          status_q <= req_bad ? ST_REJECT : ST_OK;
          state_q  <= req_bad ? S_FIN : S_CMD;
        end
        S_CMD: if (cmd_ready) state_q <= S_RSP;
        S_RSP: if (rsp_valid) begin
          if (rsp_err) begin
            status_q <= ST_BUSERR;
            state_q  <= S_FIN;
          end else begin
            state_q <= S_CMD;
            case (phase_q)
              P_START: phase_q <= P_CTRL;
              P_CTRL, P_AH, P_AL: begin
                if (rsp_nack) begin
                  status_q <= ST_NACK;
                  phase_q  <= P_END;
                end else begin
                  phase_q <= (phase_q == P_CTRL) ? P_AH :
                             (phase_q == P_AH)   ? P_AL : P_DATA;
                end
              end
              P_DATA: begin
                if (rsp_nack) begin
                  status_q <= ST_NACK;
                  phase_q  <= P_END;
                end else if (last_dat) begin
                  phase_q <= P_STOP;
                end else begin
                  idx_q <= idx_q + 1'b1;
                end
              end
              P_STOP:   phase_q <= P_PSTART;
              P_PSTART: phase_q <= P_PCTRL;
              P_PCTRL: begin
                if (!rsp_nack) begin
                  status_q <= ST_OK;
                  if (hold_q) state_q <= S_FIN;
                  else        phase_q <= P_END;
                end else if (poll_out) begin
                  status_q <= ST_TIMEOUT;
                  phase_q  <= P_END;
                end else begin
                  polls_q <= polls_nx[POLL_W-1:0];
                  phase_q <= P_PSTART;
                end
              end
              default: state_q <= S_FIN;
            endcase
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  a_r8_cmd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_op) && $stable(cmd_byte)));

  a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !cmd_valid);

  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |=> !done_valid);

  a_r1_reject_fast: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_bad) |=> (done_valid && done_status == ST_REJECT));

  a_r7_err_ends: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_RSP && rsp_valid && rsp_err) |=> (done_valid && done_status == ST_BUSERR && !cmd_valid));

  a_r5_poll_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (polls_q != '0) |-> (polls_q < maxp_q));
endmodule

// File: tb/ack_poll_sequencer_tb.sv
`timescale 1ns/1ps
module ack_poll_sequencer_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic       req_valid = 1'b0, req_ready, req_hold_bus = 1'b0;
  logic [2:0] req_cs = '0;
  logic [11:0] req_addr = '0;
  logic [5:0] req_len = '0;
  logic [7:0] req_max_polls = '0;
  logic [4:0] dat_idx;
  logic [7:0] dat_byte;
  logic       cmd_valid, cmd_ready = 1'b0;
  logic [1:0] cmd_op;
  logic [7:0] cmd_byte;
  logic       rsp_valid = 1'b0, rsp_nack = 1'b0, rsp_err = 1'b0;
  logic       done_valid;
  logic [2:0] done_status;

  int compared = 0, mismatched = 0;
  int sc_busy = 0, sc_nack_i = -1, sc_err_i = -1;
  logic [7:0] sc_seed = '0;
  logic [1:0] lg_op [64];
  logic [7:0] lg_b  [64];
  int lg_n = 0;
  logic [1:0] ex_op [64];
  logic [7:0] ex_b  [64];
  int ex_n = 0;
  logic [2:0] ex_st;

  function automatic logic [7:0] dbyte(input logic [4:0] i, input logic [7:0] s);
    return 8'h5A ^ (8'(i) * 8'd13) ^ s;
  endfunction

  assign dat_byte = dbyte(dat_idx, sc_seed);

  ack_poll_sequencer dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_cs(req_cs), .req_addr(req_addr), .req_len(req_len),
    .req_hold_bus(req_hold_bus), .req_max_polls(req_max_polls),
    .dat_idx(dat_idx), .dat_byte(dat_byte), .cmd_valid(cmd_valid),
    .cmd_ready(cmd_ready), .cmd_op(cmd_op), .cmd_byte(cmd_byte),
    .rsp_valid(rsp_valid), .rsp_nack(rsp_nack), .rsp_err(rsp_err),
    .done_valid(done_valid), .done_status(done_status));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // engine model: delay 0..2 cycles, one response per command
  initial begin
    int starts, polls, dly;
    logic [1:0] prev;
    starts = 0; polls = 0; prev = 2'd2;
    forever begin
      @(negedge clk);
      if (lg_n == 0) begin starts = 0; polls = 0; prev = 2'd2; end
      if (cmd_valid) begin
        dly = lg_n % 3;
        for (int d = 0; d < dly; d++) @(negedge clk);
        cmd_ready = 1'b1;
        if (lg_n < 64) begin lg_op[lg_n] = cmd_op; lg_b[lg_n] = cmd_byte; end
        @(negedge clk);
        cmd_ready = 1'b0;
        rsp_err  = (lg_n == sc_err_i);
        rsp_nack = (lg_n == sc_nack_i) && (cmd_op == 2'd1);
        if (cmd_op == 2'd0) starts++;
        if (cmd_op == 2'd1 && prev == 2'd0 && starts > 1) begin
          polls++;
          if (polls <= sc_busy) rsp_nack = 1'b1;
        end
        prev = lg_op[lg_n < 64 ? lg_n : 63];
        lg_n++;
        rsp_valid = 1'b1;
        @(negedge clk);
        rsp_valid = 1'b0; rsp_nack = 1'b0; rsp_err = 1'b0;
      end
    end
  end

  function automatic int epush(input logic [1:0] op, input logic [7:0] b);
    int r;
    r = (ex_n == sc_err_i) ? 2 : ((ex_n == sc_nack_i && op == 2'd1) ? 1 : 0);
    if (ex_n < 64) begin ex_op[ex_n] = op; ex_b[ex_n] = b; end
    ex_n++;
    return r;
  endfunction

  task automatic build_exp(input logic [2:0] cs, input logic [11:0] a, input int len,
                           input bit keep, input int maxp);
    int r, k;
    logic [7:0] ctl;
    logic [7:0] wb [35];
    ex_n = 0;
    if (len == 0 || (a % 32) + len > 32) begin ex_st = 3'd4; return; end
    ctl = {4'hA, cs, 1'b0};
    wb[0] = ctl; wb[1] = {4'h0, a[11:8]}; wb[2] = a[7:0];
    for (int i = 0; i < len; i++) wb[3+i] = dbyte(5'(i), sc_seed);
    if (epush(2'd0, 8'h00) == 2) begin ex_st = 3'd3; return; end
    for (int i = 0; i < len + 3; i++) begin
      r = epush(2'd1, wb[i]);
      if (r == 2) begin ex_st = 3'd3; return; end
      if (r == 1) begin
        ex_st = 3'd2;
        if (epush(2'd2, 8'h00) == 2) ex_st = 3'd3;
        return;
      end
    end
    if (epush(2'd2, 8'h00) == 2) begin ex_st = 3'd3; return; end
    k = 0;
    while (ex_n < 60) begin
      if (epush(2'd0, 8'h00) == 2) begin ex_st = 3'd3; return; end
      r = epush(2'd1, ctl);
      if (r == 2) begin ex_st = 3'd3; return; end
      k++;
      if (!(k <= sc_busy || r == 1)) begin
        ex_st = 3'd0;
        if (!keep && epush(2'd2, 8'h00) == 2) ex_st = 3'd3;
        return;
      end
      if (k >= maxp) begin
        ex_st = 3'd1;
        if (epush(2'd2, 8'h00) == 2) ex_st = 3'd3;
        return;
      end
    end
  endtask

  task automatic run(input string tag, input logic [2:0] cs, input logic [11:0] a, input int len,
                     input bit keep, input int maxp, input int busy, input int nk, input int er,
                     input logic [7:0] seed);
    int w, bad;
    logic [2:0] st;
    sc_busy = busy; sc_nack_i = nk; sc_err_i = er; sc_seed = seed;
    build_exp(cs, a, len, keep, maxp);
    lg_n = 0;
    @(negedge clk);
    req_cs = cs; req_addr = a; req_len = 6'(len); req_hold_bus = keep;
    req_max_polls = 8'(maxp); req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    w = 0;
    while (!done_valid && w < 4000) begin @(negedge clk); w++; end
    st = done_status;
    check(done_valid, {tag, " R9 done seen"}, w, 0);
    check(st == ex_st, {tag, " status"}, st, ex_st);
    @(negedge clk);
    check(!done_valid, "R9 done pulse width", done_valid, 0);
    check(lg_n == ex_n, {tag, " command count"}, lg_n, ex_n);
    bad = -1;
    for (int i = 0; i < ex_n && i < lg_n && i < 64; i++)
      if (bad < 0 && (lg_op[i] !== ex_op[i] || (ex_op[i] == 2'd1 && lg_b[i] !== ex_b[i]))) bad = i;
    if (bad >= 0) check(1'b0, {tag, " command stream"}, {22'd0, lg_op[bad], lg_b[bad]}, {22'd0, ex_op[bad], ex_b[bad]});
    else check(1'b1, {tag, " command stream"}, 0, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog R9 actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(req_ready == 1'b1, "R9 reset req_ready", req_ready, 1);
    check(cmd_valid == 1'b0, "R9 reset cmd_valid", cmd_valid, 0);
    check(done_valid == 1'b0, "R9 reset done_valid", done_valid, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(cmd_valid == 1'b0, "R8 idle no command", cmd_valid, 0);

    // R2 R3 R4: chip selects and busy counts
    for (int c = 0; c < 8; c++)
      run("R2_R3_R4 cs sweep", 3'(c), 12'h3A0 + 12'(c * 32), 1 + c, c[0], 4, c % 4, -1, -1, 8'(c * 17));
    // R1: page offsets and lengths
    for (int o = 0; o < 4; o++) begin
      int offs [4] = '{0, 1, 15, 31};
      int lens [4] = '{1, 2, 31, 32};
      for (int l = 0; l < 4; l++)
        run("R1 page sweep", 3'd5, 12'hF40 + 12'(offs[o]), lens[l], 1'b0, 2, 0, -1, -1, 8'(o * 4 + l));
    end
    run("R1 zero length", 3'd1, 12'h010, 0, 1'b0, 3, 0, -1, -1, 8'h11);
    run("R1 over length", 3'd1, 12'h000, 33, 1'b0, 3, 0, -1, -1, 8'h12);
    // R5: poll limit sweep
    for (int m = 0; m < 4; m++)
      for (int b = 0; b < 5; b++)
        run("R5 poll limit", 3'd2, 12'h7E0, 3, 1'b0, m, b, -1, -1, 8'(m * 5 + b));
    run("R4 hold bus", 3'd3, 12'hABC, 4, 1'b1, 10, 6, -1, -1, 8'h77);
    // R6: NACK on control, address and data bytes
    for (int n = 1; n < 7; n++)
      run("R6 write nack", 3'd4, 12'h123, 3, 1'b0, 4, 1, n, -1, 8'(n));
    // R7: engine error at several points
    for (int e = 0; e < 12; e += 2)
      run("R7 bus error", 3'd6, 12'h8C0, 3, 1'b0, 5, 3, -1, e, 8'(e + 40));
    run("R8 after aborts", 3'd7, 12'hFE0, 32, 1'b0, 8, 2, -1, -1, 8'hC3);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule